// File: doc/BRIEF.md
# Field Memory Control Pulse Generator

This block derives the control strobes for a field-memory video path and the drive pulses for horizontal and vertical deflection stages. It watches a horizontal reference input and a vertical reference input. It counts clocks inside each line, starting from the rising edge of the horizontal reference. It counts lines inside each field, starting from the rising edge of the vertical reference.

Both memory enables combine two windows. The write enable is high only where a horizontal window and a vertical window overlap, and the read enable is built the same way from its own pair of windows. A reset-write strobe of a fixed number of clocks starts at every vertical reference edge. Three further pulses come from their own windows: a horizontal drive, a vertical drive and a horizontal blanking pulse.

A host loads every start and stop value through a simple register port. Writes land in a staging copy. The whole set moves into the working copy at the next vertical edge, so that no window changes shape part way through a field.

Top module: `fmem_pulse_gen`

## Requirements
- R1: The pixel count returns to 0 in the clock after a rising horizontal reference edge is sampled and otherwise increments by one per clock. The line count returns to 0 after a rising vertical edge and increments by one at each rising horizontal edge. Both counts saturate at their maximum value and do not wrap.
- R2: A window is active while its count is greater than or equal to its start value and less than its stop value. A window whose start is equal to or greater than its stop is never active.
- R3: `wr_en` is high when the pixel count lies in the write horizontal window (registers 0 and 1) and the line count lies in the write vertical window (registers 2 and 3). The output is registered, so it reflects the counts of the previous clock.
- R4: `rd_en` is formed the same way from the read horizontal window (registers 4 and 5) and the read vertical window (registers 6 and 7), with the same one-clock lag.
- R5: `rst_wr` goes high in the clock after a rising vertical edge is sampled and stays high for exactly RSTW_CYC clocks. A new vertical edge during the pulse restarts the full width.
- R6: `hdrv` follows the pixel window in registers 8 and 9. `vdrv` follows the line window in registers 10 and 11. `hblank` follows the pixel window in registers 12 and 13. All three have the same one-clock lag as R3.
- R7: Register writes (`reg_we` high, index on `reg_addr`, value on `reg_wdata`) go to a staging copy. The staging copy moves into the working copy only at a rising vertical edge. A write during a field leaves that field's pulses unchanged.
- R8: While reset is held, and after it is released until values are loaded, every output is low and every start and stop value is 0.
- R9: When the horizontal and vertical edges are sampled in the same clock, the new line starts with both the line count and the pixel count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| href | input | 1 | Horizontal reference; its rising edge starts a line |
| vref | input | 1 | Vertical reference; its rising edge starts a field |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register index 0 to 13 |
| reg_wdata | input | CNT_W | Start or stop value to write |
| wr_en | output | 1 | Composite field-memory write enable |
| rd_en | output | 1 | Composite field-memory read enable |
| rst_wr | output | 1 | Write-pointer reset strobe |
| hdrv | output | 1 | Horizontal deflection drive |
| vdrv | output | 1 | Vertical deflection drive |
| hblank | output | 1 | Horizontal blanking pulse |

## Verification
A wrong pixel or line count moves every window that depends on it. The error shows on the affected enable or drive pulse within one clock after the count reaches the start value of that window, and it persists until the next reference edge realigns the count. A working copy that is corrupted or loaded too early changes the pulse widths in the same field as the write, so per-field totals of high clocks expose it. A fault in the reset-write counter shows as a pulse that is the wrong length, measured from the vertical edge.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int NUM_WIN  = 7;
  localparam int NUM_REGS = 2 * NUM_WIN;

  // window slots; registers 2k (start) and 2k+1 (stop) belong to slot k
  localparam int WIN_WR_H  = 0;
  localparam int WIN_WR_V  = 1;
  localparam int WIN_RD_H  = 2;
  localparam int WIN_RD_V  = 3;
  localparam int WIN_HDRV  = 4;
  localparam int WIN_VDRV  = 5;
  localparam int WIN_HBLNK = 6;

  function automatic bit win_is_vertical(input int k);
    return (k == WIN_WR_V) || (k == WIN_RD_V) || (k == WIN_VDRV);
  endfunction
endpackage

// File: rtl/fpg_window.sv
module fpg_window #(
  parameter int W = 12
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] start,
  input  logic [W-1:0] stop,
  output logic         hit
);
  // half-open interval [start, stop); empty when start >= stop
  always_comb begin
    hit = (cnt >= start) && (cnt < stop);
  end
endmodule

// File: rtl/fpg_timebase.sv
module fpg_timebase #(
  parameter int CNT_W  = 12,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_l,
  input  logic              href,
  input  logic              vref,
  output logic              h_edge,
  output logic              v_edge,
  output logic [CNT_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt
);
  localparam logic [CNT_W-1:0]  PMAX = '1;
  localparam logic [LINE_W-1:0] LMAX = '1;

  logic              href_q, vref_q;
  logic [CNT_W-1:0]  pix_d;
  logic [LINE_W-1:0] line_d;

  always_comb begin
    h_edge = href & ~href_q;
    v_edge = vref & ~vref_q;
    if (h_edge)               pix_d = '0;
    else if (pix_cnt != PMAX) pix_d = pix_cnt + 1'b1;
    else                      pix_d = pix_cnt;
    if (v_edge)                         line_d = '0;
    else if (h_edge && line_cnt != LMAX) line_d = line_cnt + 1'b1;
    else                                line_d = line_cnt;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      href_q   <= 1'b0;
      vref_q   <= 1'b0;
      pix_cnt  <= '0;
      line_cnt <= '0;
    end else begin
      href_q   <= href;
      vref_q   <= vref;
      pix_cnt  <= pix_d;
      line_cnt <= line_d;
    end
  end

  assert_pix_restart_R1: assert property (@(posedge clk) disable iff (!rst_l)
    h_edge |=> (pix_cnt == '0));

  assert_line_step_R1: assert property (@(posedge clk) disable iff (!rst_l)
    (h_edge && !v_edge && line_cnt != LMAX) |=> (line_cnt == LINE_W'($past(line_cnt) + 1'b1)));

  assert_joint_edge_R9: assert property (@(posedge clk) disable iff (!rst_l)
    (h_edge && v_edge) |=> (line_cnt == '0 && pix_cnt == '0));
endmodule

// File: rtl/fpg_regbank.sv
module fpg_regbank
  import fpg_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_l,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [CNT_W-1:0]                  wdata,
  input  logic                              load,
  output logic [NUM_REGS-1:0][CNT_W-1:0]    act_q
);
  logic [NUM_REGS-1:0][CNT_W-1:0] stg_q, stg_d, act_d;

  always_comb begin
    stg_d = stg_q;
    if (we && (int'(addr) < NUM_REGS)) stg_d[addr] = wdata;
    act_d = load ? stg_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      stg_q <= '0;
      act_q <= '0;
    end else begin
      stg_q <= stg_d;
      act_q <= act_d;
    end
  end

  assert_active_held_R7: assert property (@(posedge clk) disable iff (!rst_l)
    !load |=> $stable(act_q));
endmodule

// File: rtl/fpg_rstw.sv
module fpg_rstw #(
  parameter int RSTW_CYC = 1728
) (
  input  logic clk,
  input  logic rst_l,
  input  logic trig,
  output logic pulse
);
  localparam int RW = $clog2(RSTW_CYC + 1);
  localparam logic [RW-1:0] LOADV = RW'(RSTW_CYC - 1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          pulse_d;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = pulse;
    if (trig) begin
      cnt_d   = LOADV;
      pulse_d = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d   = cnt_q - 1'b1;
    end else begin
      pulse_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pulse <= pulse_d;
    end
  end

  assert_rstw_start_R5: assert property (@(posedge clk) disable iff (!rst_l)
    trig |=> pulse);

  assert_rstw_end_R5: assert property (@(posedge clk) disable iff (!rst_l)
    (cnt_q == '0 && !trig) |=> !pulse);
endmodule

// File: rtl/fmem_pulse_gen.sv
module fmem_pulse_gen
  import fpg_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int LINE_W   = 10,
  parameter int RSTW_CYC = 1728,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              href,
  input  logic              vref,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic              wr_en,
  output logic              rd_en,
  output logic              rst_wr,
  output logic              hdrv,
  output logic              vdrv,
  output logic              hblank
);
  logic [1:0]                     rst_sync;
  logic                           rst_l;
  logic                           h_edge, v_edge;
  logic [CNT_W-1:0]               pix_cnt, line_ext;
  logic [LINE_W-1:0]              line_cnt;
  logic [NUM_REGS-1:0][CNT_W-1:0] act;
  logic [NUM_WIN-1:0]             hit;
  logic                           wr_d, rd_d, hd_d, vd_d, hb_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_l = rst_sync[1];

  fpg_timebase #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_tb (
    .clk(clk), .rst_l(rst_l), .href(href), .vref(vref),
    .h_edge(h_edge), .v_edge(v_edge), .pix_cnt(pix_cnt), .line_cnt(line_cnt));

  fpg_regbank #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_l(rst_l), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .load(v_edge), .act_q(act));

  fpg_rstw #(.RSTW_CYC(RSTW_CYC)) u_rstw (
    .clk(clk), .rst_l(rst_l), .trig(v_edge), .pulse(rst_wr));

  assign line_ext = CNT_W'(line_cnt);

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam bit VSEL = win_is_vertical(k);
    logic [CNT_W-1:0] sel;
    if (VSEL) begin : g_v
      assign sel = line_ext;
    end else begin : g_h
      assign sel = pix_cnt;
    end
    fpg_window #(.W(CNT_W)) u_w (
      .cnt(sel), .start(act[2*k]), .stop(act[2*k+1]), .hit(hit[k]));
  end

  always_comb begin
    wr_d = hit[WIN_WR_H] & hit[WIN_WR_V];
    rd_d = hit[WIN_RD_H] & hit[WIN_RD_V];
    hd_d = hit[WIN_HDRV];
    vd_d = hit[WIN_VDRV];
    hb_d = hit[WIN_HBLNK];
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      wr_en  <= 1'b0;
      rd_en  <= 1'b0;
      hdrv   <= 1'b0;
      vdrv   <= 1'b0;
      hblank <= 1'b0;
    end else begin
      wr_en  <= wr_d;
      rd_en  <= rd_d;
      hdrv   <= hd_d;
      vdrv   <= vd_d;
      hblank <= hb_d;
    end
  end

  assert_wr_in_field_R3: assert property (@(posedge clk) disable iff (!rst_l)
    wr_en |-> $past(hit[WIN_WR_V]));

  assert_rd_in_line_R4: assert property (@(posedge clk) disable iff (!rst_l)
    rd_en |-> $past(hit[WIN_RD_H]));
endmodule

// File: tb/fmem_pulse_gen_bench.sv
module fmem_pulse_gen_bench;
  localparam int CW = 12, LW = 10, RW = 20, AW = 4, NR = 14;

  logic clk = 1'b0, rst_n = 1'b0, href = 1'b0, vref = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic wr_en, rd_en, rst_wr, hdrv, vdrv, hblank;

  int checks = 0, fails = 0;
  bit done = 0, cmp_en = 0, cnt_en = 0;
  int n_wr, n_rd, n_rs, n_hd, n_vd, n_hb;

  always #5 clk = ~clk;

  fmem_pulse_gen #(.CNT_W(CW), .LINE_W(LW), .RSTW_CYC(RW), .ADDR_W(AW)) u_fmem_pulse_gen (
    .clk(clk), .rst_n(rst_n), .href(href), .vref(vref), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rst_wr(rst_wr), .hdrv(hdrv), .vdrv(vdrv), .hblank(hblank));

  // reference model built from the requirements
  int m_pix, m_line, m_rc;
  bit m_hq, m_vq, m_rst, e_wr, e_rd, e_hd, e_vd, e_hb;
  int m_stg[NR], m_act[NR];

  function automatic bit win(input int c, input int s, input int e);
    return (c >= s) && (c < e);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pix = 0; m_line = 0; m_rc = 0; m_hq = 0; m_vq = 0; m_rst = 0;
      e_wr = 0; e_rd = 0; e_hd = 0; e_vd = 0; e_hb = 0;
      for (int i = 0; i < NR; i++) begin m_stg[i] = 0; m_act[i] = 0; end
    end else begin
      bit he, ve;
      he = href && !m_hq;
      ve = vref && !m_vq;
      e_wr = win(m_pix, m_act[0], m_act[1]) && win(m_line, m_act[2], m_act[3]);
      e_rd = win(m_pix, m_act[4], m_act[5]) && win(m_line, m_act[6], m_act[7]);
      e_hd = win(m_pix, m_act[8], m_act[9]);
      e_vd = win(m_line, m_act[10], m_act[11]);
      e_hb = win(m_pix, m_act[12], m_act[13]);
      if (ve) begin m_rc = RW - 1; m_rst = 1; end
      else if (m_rc != 0) m_rc--;
      else m_rst = 0;
      if (ve) for (int i = 0; i < NR; i++) m_act[i] = m_stg[i];
      if (reg_we && int'(reg_addr) < NR) m_stg[reg_addr] = int'(reg_wdata);
      if (he) m_pix = 0; else if (m_pix != 4095) m_pix++;
      if (ve) m_line = 0; else if (he && m_line != 1023) m_line++;
      m_hq = href; m_vq = vref;
    end
  end

  task automatic cmp(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      cmp(wr_en, e_wr, "R3 wr_en");
      cmp(rd_en, e_rd, "R4 rd_en");
      cmp(rst_wr, m_rst, "R5 rst_wr");
      cmp(hdrv, e_hd, "R6 hdrv");
      cmp(vdrv, e_vd, "R6 vdrv");
      cmp(hblank, e_hb, "R6 hblank");
    end
    if (cnt_en) begin
      n_wr += int'(wr_en); n_rd += int'(rd_en); n_rs += int'(rst_wr);
      n_hd += int'(hdrv); n_vd += int'(vdrv); n_hb += int'(hblank);
    end
  end

  task automatic clr_counts();
    n_wr = 0; n_rd = 0; n_rs = 0; n_hd = 0; n_vd = 0; n_hb = 0;
  endtask

  task automatic reg_wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = CW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // one field: href high 3 clocks per line, vref high for vl lines from line 0
  task automatic run_field(input int nl, input int ll, input int vl,
                           input int wl, input int wa, input int wd);
    clr_counts();
    cnt_en = 1;
    for (int l = 0; l < nl; l++) begin
      for (int c = 0; c < ll; c++) begin
        @(negedge clk);
        href = (c < 3);
        vref = (l < vl);
        if (l == wl && c == 1) begin
          reg_we = 1'b1; reg_addr = AW'(wa); reg_wdata = CW'(wd);
        end else reg_we = 1'b0;
      end
    end
    @(negedge clk);
    cnt_en = 0;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    cmp(wr_en | rd_en | rst_wr | hdrv | vdrv | hblank, 1'b0, "R8 outputs in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    cmp(wr_en | rd_en | rst_wr | hdrv | vdrv | hblank, 1'b0, "R8 outputs after reset");
    cmp_en = 1;
    clr_counts();
    cnt_en = 1;
    repeat (20) begin @(negedge clk); href = ~href; end
    @(negedge clk); href = 1'b0; cnt_en = 0;
    chk_int("R8 zero values keep outputs low", n_wr + n_rd + n_hd + n_vd + n_hb, 0);
  endtask

  task automatic t_program_field();
    reg_wr(0, 5);  reg_wr(1, 20); reg_wr(2, 2);  reg_wr(3, 6);
    reg_wr(4, 10); reg_wr(5, 30); reg_wr(6, 3);  reg_wr(7, 8);
    reg_wr(8, 0);  reg_wr(9, 4);  reg_wr(10, 0); reg_wr(11, 3);
    reg_wr(12, 30); reg_wr(13, 40);
    repeat (3) @(negedge clk);
    chk_int("R7 staged values not yet active", int'(wr_en | rd_en | hdrv), 0);
    run_field(12, 48, 2, -1, 0, 0);
    chk_int("R3 write enable clocks per field", n_wr, 60);
    chk_int("R4 read enable clocks per field", n_rd, 100);
    chk_int("R6 hdrv clocks per field", n_hd, 48);
    chk_int("R6 hblank clocks per field", n_hb, 120);
    chk_int("R9 vdrv from line 0 on joint edge", n_vd, 144);
    chk_int("R5 rst_wr width", n_rs, RW);
  endtask

  task automatic t_deferred_update();
    run_field(12, 48, 2, 1, 1, 5);
    chk_int("R7 mid-field write deferred", n_wr, 60);
    run_field(12, 48, 2, -1, 0, 0);
    chk_int("R2 start equal stop never active", n_wr, 0);
    chk_int("R4 read unaffected by write change", n_rd, 100);
  endtask

  task automatic t_retrigger();
    clr_counts();
    cnt_en = 1;
    @(negedge clk); vref = 1'b1;
    @(negedge clk);
    @(negedge clk); vref = 1'b0;
    repeat (7) @(negedge clk);
    @(negedge clk); vref = 1'b1;
    @(negedge clk);
    @(negedge clk); vref = 1'b0;
    repeat (35) @(negedge clk);
    cnt_en = 0;
    chk_int("R5 retriggered rst_wr width", n_rs, 10 + RW);
  endtask

  task automatic t_saturate();
    run_field(1, 4200, 0, -1, 0, 0);
    chk_int("R1 pixel count saturates", n_hd, 4);
    chk_int("R6 hblank on long line", n_hb, 10);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_program_field();
    t_deferred_update();
    t_retrigger();
    t_saturate();
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule